// File: doc/BRIEF.md
# Instruction Line Fill Buffer Controller

This block sits beside an instruction cache and keeps a copy of the last 16-byte line that was fetched from outside the chip. On each instruction fetch it chooses one of three sources. The tag array is used on a cache hit. The fill buffer is used when it holds the requested line. When neither can serve the fetch, the block issues an external request. The size of that request, a four-longword burst or a single longword, depends on a 2-bit fill mode and on which half of the line the miss falls in.

A burst returns longwords starting at the critical word and wrapping within the line. Each burst longword is written into the buffer. The first longword of any transfer is forwarded straight to the fetch port. Fetches that are non-cacheable, or that occur while the cache is disabled, bypass the tag array and the buffer. They always go out as a single longword. A full cache invalidation empties the buffer.

Top module: `ifb_ctrl`

## Requirements
- R1: With the cache enabled and the fetch cacheable, a fetch with tagHit high is answered in the same cycle: fetchReady=1, fetchData=tagData and extReq=0. The tag array has priority over the buffer.
- R2: With the cache enabled, the fetch cacheable and tagHit low, a fetch is answered in the same cycle from the buffer when the buffer is valid and fetchAddr[31:4] equals the stored line address. Then fetchReady=1, fetchData is the stored longword selected by fetchAddr[3:2], and extReq=0.
- R3: extReq is high for exactly one cycle, and only for a fetch that misses both the tag array and the buffer. While extReq is high, extAddr equals fetchAddr with bits [1:0] forced to 0. extLine=1 requests four longwords and extLine=0 requests one.
- R4: A burst delivers four beats on extDataValid, for longword indices c, c+1, c+2, c+3 modulo 4, where c=fetchAddr[3:2]. Every beat writes the buffer and raises bufLoad in that cycle. The line becomes valid in the cycle after its fourth beat.
- R5: For a cacheable miss with the cache enabled, the fill mode is decoded as follows. 2'b00 requests a burst. 2'b01 requests a burst when fetchAddr[3]=0 and a single longword when fetchAddr[3]=1. 2'b10 requests a burst. 2'b11 requests a single longword.
- R6: A fetch with fetchCacheable=0, or with cacheEnable=0, ignores tagHit and the buffer. It always issues a single-longword request, and bufLoad stays 0.
- R7: invalidateAll makes the buffer invalid from the next cycle. A burst still in progress when invalidateAll arrives leaves the buffer invalid when it ends.
- R8: On the first beat of any external transfer, fetchReady=1 and fetchData=extData. On later beats fetchReady=0.
- R9: Reset leaves the buffer invalid, with fetchReady, extReq and bufLoad low.
- R10: A single-longword transfer does not change the buffer's contents or its validity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | Fetch request, held until fetchReady |
| fetchAddr | input | 32 | Fetch byte address |
| fetchCacheable | input | 1 | Fetch is to cacheable space |
| tagHit | input | 1 | Tag array hit result for fetchAddr |
| tagData | input | 32 | Longword read from the cache data array |
| cacheEnable | input | 1 | Cache enable bit |
| fillMode | input | 2 | Line-fill size mode |
| invalidateAll | input | 1 | Full cache invalidation strobe |
| extDataValid | input | 1 | External longword beat valid |
| extData | input | 32 | External longword beat data |
| extReq | output | 1 | One-cycle external fetch request |
| extAddr | output | 32 | Longword-aligned external address |
| extLine | output | 1 | 1 = four-longword burst, 0 = single longword |
| fetchData | output | 32 | Instruction data returned to the fetch port |
| fetchReady | output | 1 | fetchData is valid for the current fetch |
| bufLoad | output | 1 | A beat is being written into the buffer |

## Verification
The hardest case to reach from the ports is an invalidation that lands in the middle of a burst. In that case a line that looks complete must still be left unusable. The bench starts a burst at a non-zero critical word and raises invalidateAll on the third beat. It then refetches the same line and expects a new external request. The wrap order is checked without any view of the storage. Every beat carries data derived from its own longword address, and each longword is then read back through buffer hits.

// File: rtl/ifb_pkg.sv
package ifb_pkg;

  typedef enum logic [1:0] {
    MODE_LINE  = 2'b00,
    MODE_HALF  = 2'b01,
    MODE_ANY   = 2'b10,
    MODE_WORD  = 2'b11
  } fillMode_e;

  typedef enum logic [1:0] {
    SEL_TAG = 2'b00,
    SEL_BUF = 2'b01,
    SEL_EXT = 2'b10
  } dataSel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ifbState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     startFill;
    logic     writeWord;
    logic     endFill;
    dataSel_e sel;
  } ifbStrobes_t;

endpackage

// File: rtl/ifb_datapath.sv
module ifb_datapath
  import ifb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ifbStrobes_t       strobes,
  input  logic              invalidateAll,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [DATA_W-1:0] tagData,
  input  logic [DATA_W-1:0] extData,
  output logic              bufHit,
  output logic              bufValid,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] fetchData
);

  localparam int BOFF_W = $clog2(DATA_W / 8);
  localparam int WIDX_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BOFF_W + WIDX_W;
  localparam int TAG_W  = ADDR_W - OFF_W;

  logic [TAG_W-1:0]  lineTag;
  logic [WIDX_W-1:0] wrIdx;
  logic              fillClean;
  logic [DATA_W-1:0] words [LINE_WORDS];
  logic [DATA_W-1:0] bufWord;

  logic [TAG_W-1:0]  reqTag;
  logic [WIDX_W-1:0] reqIdx;
  logic              unusedAddrLow;

  assign reqTag        = fetchAddr[ADDR_W-1:OFF_W];
  assign reqIdx        = fetchAddr[OFF_W-1:BOFF_W];
  assign unusedAddrLow = ^fetchAddr[BOFF_W-1:0];

  // Line address, valid flag and write pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineTag   <= '0;
      wrIdx     <= '0;
      bufValid  <= 1'b0;
      fillClean <= 1'b0;
    end else begin
      if (strobes.startFill) begin
        lineTag   <= reqTag;
        wrIdx     <= reqIdx;
        bufValid  <= 1'b0;
        fillClean <= 1'b1;
      end
      if (strobes.writeWord) begin
        wrIdx <= wrIdx + 1'b1;
      end
      if (strobes.endFill) begin
        bufValid <= fillClean;
      end
      if (invalidateAll) begin
        bufValid  <= 1'b0;
        fillClean <= 1'b0;
      end
    end
  end

  // One register per longword of the line
  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        words[w] <= '0;
      end else if (strobes.writeWord && (wrIdx == WIDX_W'(w))) begin
        words[w] <= extData;
      end
    end
  end

  assign bufWord = words[reqIdx];
  assign bufHit  = bufValid && (lineTag == reqTag);
  assign extAddr = {fetchAddr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};

  always_comb begin
    unique case (strobes.sel)
      SEL_TAG: fetchData = tagData;
      SEL_BUF: fetchData = bufWord;
      default: fetchData = extData;
    endcase
  end

endmodule

// File: rtl/ifb_control.sv
module ifb_control
  import ifb_pkg::*;
#(
  parameter int LINE_WORDS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fetchValid,
  input  logic        fetchCacheable,
  input  logic        tagHit,
  input  logic        cacheEnable,
  input  logic [1:0]  fillMode,
  input  logic        secondHalf,
  input  logic        bufHit,
  input  logic        extDataValid,
  output ifbStrobes_t strobes,
  output logic        extReq,
  output logic        extLine,
  output logic        fetchReady,
  output logic        bufLoad
);

  localparam int CNT_W = $clog2(LINE_WORDS + 1);

  ifbState_e        state;
  logic             lineFill;
  logic             firstBeat;
  logic [CNT_W-1:0] beatsLeft;

  logic lookupOk;
  logic wantLine;
  logic lastBeat;

  assign lookupOk = cacheEnable && fetchCacheable;
  assign lastBeat = (beatsLeft == CNT_W'(1));

  // Transfer size decode
  always_comb begin
    wantLine = 1'b0;
    if (lookupOk) begin
      unique case (fillMode_e'(fillMode))
        MODE_LINE: wantLine = 1'b1;
        MODE_HALF: wantLine = !secondHalf;
        MODE_ANY:  wantLine = 1'b1;
        default:   wantLine = 1'b0;
      endcase
    end
  end

  always_comb begin
    strobes    = '{startFill: 1'b0, writeWord: 1'b0, endFill: 1'b0, sel: SEL_EXT};
    extReq     = 1'b0;
    extLine    = 1'b0;
    fetchReady = 1'b0;
    bufLoad    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (fetchValid) begin
          if (lookupOk && tagHit) begin
            strobes.sel = SEL_TAG;
            fetchReady  = 1'b1;
          end else if (lookupOk && bufHit) begin
            strobes.sel = SEL_BUF;
            fetchReady  = 1'b1;
          end else begin
            extReq            = 1'b1;
            extLine           = wantLine;
            strobes.startFill = wantLine;
          end
        end
      end
      default: begin
        if (extDataValid) begin
          strobes.sel       = SEL_EXT;
          fetchReady        = firstBeat;
          strobes.writeWord = lineFill;
          bufLoad           = lineFill;
          strobes.endFill   = lineFill && lastBeat;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      lineFill  <= 1'b0;
      firstBeat <= 1'b0;
      beatsLeft <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (extReq) begin
            state     <= ST_WAIT;
            lineFill  <= wantLine;
            firstBeat <= 1'b1;
            beatsLeft <= wantLine ? CNT_W'(LINE_WORDS) : CNT_W'(1);
          end
        end
        default: begin
          if (extDataValid) begin
            firstBeat <= 1'b0;
            beatsLeft <= beatsLeft - 1'b1;
            if (lastBeat) begin
              state <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ifb_ctrl.sv
module ifb_ctrl
  import ifb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchCacheable,
  input  logic              tagHit,
  input  logic [DATA_W-1:0] tagData,
  input  logic              cacheEnable,
  input  logic [1:0]        fillMode,
  input  logic              invalidateAll,
  input  logic              extDataValid,
  input  logic [DATA_W-1:0] extData,
  output logic              extReq,
  output logic [ADDR_W-1:0] extAddr,
  output logic              extLine,
  output logic [DATA_W-1:0] fetchData,
  output logic              fetchReady,
  output logic              bufLoad
);

  localparam int HALF_BIT = $clog2(DATA_W / 8) + $clog2(LINE_WORDS) - 1;

  ifbStrobes_t strobes;
  logic        bufHit;
  logic        bufValid;

  ifb_control #(.LINE_WORDS(LINE_WORDS)) u_control (
    .clk           (clk),
    .rstN          (rstN),
    .fetchValid    (fetchValid),
    .fetchCacheable(fetchCacheable),
    .tagHit        (tagHit),
    .cacheEnable   (cacheEnable),
    .fillMode      (fillMode),
    .secondHalf    (fetchAddr[HALF_BIT]),
    .bufHit        (bufHit),
    .extDataValid  (extDataValid),
    .strobes       (strobes),
    .extReq        (extReq),
    .extLine       (extLine),
    .fetchReady    (fetchReady),
    .bufLoad       (bufLoad)
  );

  ifb_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LINE_WORDS(LINE_WORDS)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .invalidateAll(invalidateAll),
    .fetchAddr    (fetchAddr),
    .tagData      (tagData),
    .extData      (extData),
    .bufHit       (bufHit),
    .bufValid     (bufValid),
    .extAddr      (extAddr),
    .fetchData    (fetchData)
  );

endmodule

// File: rtl/ifb_ctrl_chk.sv
module ifb_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchValid,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              fetchCacheable,
  input logic              tagHit,
  input logic              cacheEnable,
  input logic [1:0]        fillMode,
  input logic              invalidateAll,
  input logic              extDataValid,
  input logic              extReq,
  input logic [ADDR_W-1:0] extAddr,
  input logic              extLine,
  input logic              bufLoad,
  input logic              bufValid
);

  AST_REQ_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    extReq |-> fetchValid); // R3
  AST_TAG_HIT_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    extReq |-> !(cacheEnable && fetchCacheable && tagHit)); // R1
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    extReq |=> !extReq); // R3
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    extReq |-> (extAddr[1:0] == 2'b00 && extAddr[ADDR_W-1:2] == fetchAddr[ADDR_W-1:2])); // R3
  AST_UNCACHED_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (extReq && !(cacheEnable && fetchCacheable)) |-> !extLine); // R6
  AST_MODE_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (extReq && fillMode == 2'b11) |-> !extLine); // R5
  AST_MODE_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (extReq && cacheEnable && fetchCacheable && fillMode == 2'b01) |-> (extLine == !fetchAddr[3])); // R5
  AST_LOAD_ON_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    bufLoad |-> extDataValid); // R4
  AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufValid) |-> $past(bufLoad)); // R4
  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    invalidateAll |=> !bufValid); // R7

endmodule

bind ifb_ctrl ifb_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .fetchValid    (fetchValid),
  .fetchAddr     (fetchAddr),
  .fetchCacheable(fetchCacheable),
  .tagHit        (tagHit),
  .cacheEnable   (cacheEnable),
  .fillMode      (fillMode),
  .invalidateAll (invalidateAll),
  .extDataValid  (extDataValid),
  .extReq        (extReq),
  .extAddr       (extAddr),
  .extLine       (extLine),
  .bufLoad       (bufLoad),
  .bufValid      (bufValid)
);

// File: tb/ifb_ctrl_tb.sv
module ifb_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        fetchCacheable = 1'b0;
  logic        tagHit = 1'b0;
  logic [31:0] tagData = '0;
  logic        cacheEnable = 1'b0;
  logic [1:0]  fillMode = 2'b00;
  logic        invalidateAll = 1'b0;
  logic        extDataValid = 1'b0;
  logic [31:0] extData = '0;
  logic        extReq;
  logic [31:0] extAddr;
  logic        extLine;
  logic [31:0] fetchData;
  logic        fetchReady;
  logic        bufLoad;

  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  ifb_ctrl u_dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchCacheable(fetchCacheable), .tagHit(tagHit), .tagData(tagData),
    .cacheEnable(cacheEnable), .fillMode(fillMode), .invalidateAll(invalidateAll),
    .extDataValid(extDataValid), .extData(extData), .extReq(extReq),
    .extAddr(extAddr), .extLine(extLine), .fetchData(fetchData),
    .fetchReady(fetchReady), .bufLoad(bufLoad)
  );

  function automatic logic [31:0] wordVal(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC3C3_5A5A;
  endfunction

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic goIdle();
    @(negedge clk);
    fetchValid = 1'b0; tagHit = 1'b0; invalidateAll = 1'b0; extDataValid = 1'b0;
  endtask

  // Fetch expected to be answered in the same cycle (tag array or buffer)
  task automatic hitProbe(input logic [31:0] addr, input logic tag,
                          input logic [31:0] tdata, input logic [31:0] expData,
                          input string req);
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = addr; fetchCacheable = 1'b1; cacheEnable = 1'b1;
    tagHit = tag; tagData = tdata; extDataValid = 1'b0; invalidateAll = 1'b0;
    #1;
    checkEq(req, "hit ready", 32'(fetchReady), 32'd1);
    checkEq(req, "hit data", fetchData, expData);
    checkEq(req, "hit no request", 32'(extReq), 32'd0);
    @(posedge clk);
    goIdle();
  endtask

  // Fetch expected to miss; delivers the beats in wrap order
  task automatic missFill(input logic [31:0] addr, input logic [1:0] mode,
                          input logic cacheable, input logic enable, input logic tag,
                          input logic expLine, input int invalBeat, input string req);
    int beats;
    logic [1:0] crit;
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = addr; fetchCacheable = cacheable; cacheEnable = enable;
    tagHit = tag; tagData = 32'hDEAD_BEEF; fillMode = mode;
    extDataValid = 1'b0; invalidateAll = 1'b0;
    #1;
    checkEq(req, "request", 32'(extReq), 32'd1);
    checkEq(req, "size", 32'(extLine), 32'(expLine));
    checkEq(req, "ext address", extAddr, {addr[31:2], 2'b00});
    @(posedge clk);
    beats = expLine ? 4 : 1;
    crit = addr[3:2];
    for (int i = 0; i < beats; i++) begin
      @(negedge clk);
      fetchValid = (i == 0);
      tagHit = 1'b0;
      invalidateAll = (i == invalBeat);
      extDataValid = 1'b1;
      extData = wordVal({addr[31:4], 2'(crit + 2'(i)), 2'b00});
      #1;
      checkEq(req, "load strobe", 32'(bufLoad), 32'(expLine));
      checkEq("R3", "request stays low", 32'(extReq), 32'd0);
      checkEq("R8", "beat ready", 32'(fetchReady), (i == 0) ? 32'd1 : 32'd0);
      if (i == 0) checkEq("R8", "critical data", fetchData, extData);
      @(posedge clk);
    end
    goIdle();
  endtask

  task automatic doInvalidate();
    @(negedge clk);
    fetchValid = 1'b0; invalidateAll = 1'b1;
    @(posedge clk);
    goIdle();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; fetchValid = 1'b0; extDataValid = 1'b0; invalidateAll = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    checkEq("R9", "ready in reset", 32'(fetchReady), 32'd0);
    checkEq("R9", "request in reset", 32'(extReq), 32'd0);
    checkEq("R9", "load in reset", 32'(bufLoad), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testTagHit();
    hitProbe(32'h0000_2000, 1'b1, 32'h1111_2222, 32'h1111_2222, "R1");
  endtask

  task automatic testBurstAndWrap();
    missFill(32'h0000_1008, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, -1, "R4");
    for (int w = 0; w < 4; w++)
      hitProbe(32'h0000_1000 + 32'(w * 4), 1'b0, 32'h0, wordVal(32'h0000_1000 + 32'(w * 4)), "R2");
  endtask

  task automatic testModes();
    missFill(32'h0000_3004, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, -1, "R5");
    hitProbe(32'h0000_3000, 1'b0, 32'h0, wordVal(32'h0000_3000), "R2");
    missFill(32'h0000_400C, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, -1, "R5");
    hitProbe(32'h0000_3008, 1'b0, 32'h0, wordVal(32'h0000_3008), "R10");
    missFill(32'h0000_5008, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, -1, "R5");
    missFill(32'h0000_6000, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, -1, "R5");
    hitProbe(32'h0000_5004, 1'b0, 32'h0, wordVal(32'h0000_5004), "R10");
  endtask

  task automatic testUncached();
    missFill(32'h0000_5004, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, -1, "R6");
    missFill(32'h0000_5004, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, -1, "R6");
    missFill(32'h0000_5004, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, -1, "R6");
    hitProbe(32'h0000_500C, 1'b0, 32'h0, wordVal(32'h0000_500C), "R6");
  endtask

  task automatic testInvalidate();
    doInvalidate();
    missFill(32'h0000_5004, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, -1, "R7");
    missFill(32'h0000_7004, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 2, "R7");
    missFill(32'h0000_7004, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, -1, "R7");
    hitProbe(32'h0000_7000, 1'b0, 32'h0, wordVal(32'h0000_7000), "R2");
  endtask

  task automatic testResetClears();
    doReset();
    missFill(32'h0000_7000, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, -1, "R9");
  endtask

  initial begin
    doReset();
    missFill(32'h0000_0100, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, -1, "R9");
    testTagHit();
    testBurstAndWrap();
    testModes();
    testUncached();
    testInvalidate();
    testResetClears();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule